// File: doc/BRIEF.md
# Saturating Signed Subtractor with Sticky Status

This block subtracts one signed two's-complement operand from another and returns the difference in one of two modes. In wrap mode the difference is taken modulo 2^W. In saturating mode a difference that falls outside the signed range is clamped to the nearest bound. Each accepted operation also reports a signed-overflow flag and an advance-overflow flag. The advance-overflow flag warns that the difference has used up its top guard bit. Two sticky copies collect these flags across many operations. A datapath places the block after its product stage and reads the flags once a whole series of operations has finished.

Operations are accepted on cycles with `in_valid` high. The result, the flags and the sticky flags are registered and appear on the following cycle together with `out_valid`. Between operations every registered output keeps its value. A synchronous `sticky_clr` clears the two sticky flags and leaves the result and the per-operation flags as they are. The operand width is a parameter (default 64). A second parameter removes the clamp logic for datapaths that only ever wrap.

Top module: `msub_sat_unit`

## Requirements
- R1: While reset is held and after it is released, with no operation yet accepted, `out_valid`, `result`, `ovf`, `adv`, `ovf_sticky` and `adv_sticky` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: With `sat_en` = 0, `result` equals (`minuend` − `subtrahend`) mod 2^W. With `sat_en` = 1, the same holds whenever the operation does not overflow.
- R4: `ovf` is 1 after an operation whose signed difference lies outside [−2^(W−1), 2^(W−1)−1], and it is 0 after any operation that stays inside that range.
- R5: With `sat_en` = 1 and an overflowing operation, `result` is 2^(W−1)−1 (a 0 sign bit followed by all ones) when `minuend` bit W−1 is 0, and 2^(W−1) (a 1 sign bit followed by all zeros) when it is 1.
- R6: `adv` equals bit W−1 XOR bit W−2 of the wrapped, unclamped difference, in both modes.
- R7: After an operation, `ovf_sticky` and `adv_sticky` each equal their previous value ORed with that operation's `ovf` and `adv` respectively.
- R8: `sticky_clr` high at a clock edge clears both sticky flags. If an operation is accepted at the same edge, its new flags are ORed into the cleared value. `result`, `ovf` and `adv` are not changed by the clear.
- R9: In a cycle with `in_valid` low, `result`, `ovf`, `adv` and the sticky flags hold their values. The one exception is the clear in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| sat_en | input | 1 | 1 = saturating mode, 0 = wrap mode |
| minuend | input | W | Signed left operand |
| subtrahend | input | W | Signed right operand |
| sticky_clr | input | 1 | Synchronous clear of both sticky flags |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | W | Difference, wrapped or clamped |
| ovf | output | 1 | Signed overflow of the last operation |
| adv | output | 1 | Advance overflow of the last operation |
| ovf_sticky | output | 1 | Accumulated overflow |
| adv_sticky | output | 1 | Accumulated advance overflow |

## Verification
The bench builds the block with W = 6 and the clamp logic enabled. At that width every minuend–subtrahend pair, 4096 in all, can be applied in both modes. The sweep therefore reaches both clamp bounds, every operand pair on both sides of the overflow boundary, and each combination of the two top difference bits. Sticky clears are placed at fixed points in the sweep, some of them at the same edge as an operation. Directed idle cycles confirm that the outputs hold, and that a clear with no operation leaves the result untouched.

// File: rtl/msub_pkg.sv
package msub_pkg;
   typedef struct packed {
      logic ovf;
      logic adv;
   } msub_flags_t;
endpackage

// File: rtl/msub_diff.sv
module msub_diff #(
   parameter int W = 64
) (
   input  logic [W-1:0]             a,
   input  logic [W-1:0]             b,
   output logic [W-1:0]             diff,
   output msub_pkg::msub_flags_t    flags
);
   localparam int MSB = W - 1;

   logic [W-1:0] sign_mix;

   always_comb begin
      diff      = a - b;
      sign_mix  = (diff ^ a) & (a ^ b);
      flags.ovf = sign_mix[MSB];
      flags.adv = diff[MSB] ^ diff[MSB-1];
   end
endmodule

// File: rtl/msub_clamp.sv
module msub_clamp #(
   parameter int W           = 64,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic         sat_en,
   input  logic         ovf,
   input  logic         a_sign,
   input  logic [W-1:0] diff,
   output logic [W-1:0] res
);
   localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

   generate
      if (SAT_SUPPORT) begin : g_sat
         always_comb begin
            if (sat_en && ovf) res = a_sign ? NEG_LIMIT : POS_LIMIT;
            else               res = diff;
         end
      end else begin : g_wrap
         logic unused_ctl;
         assign unused_ctl = sat_en ^ ovf ^ a_sign;
         assign res        = diff;
      end
   endgenerate
endmodule

// File: rtl/msub_flag_reg.sv
module msub_flag_reg #(
   parameter int W = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  clr,
   input  logic [W-1:0]          res_d,
   input  msub_pkg::msub_flags_t flg_d,
   output logic                  vld_q,
   output logic [W-1:0]          res_q,
   output msub_pkg::msub_flags_t flg_q,
   output msub_pkg::msub_flags_t stk_q
);
   msub_pkg::msub_flags_t stk_base;

   always_comb stk_base = clr ? '0 : stk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
         flg_q <= '0;
         stk_q <= '0;
      end else begin
         vld_q <= load;
         if (load) begin
            res_q <= res_d;
            flg_q <= flg_d;
            stk_q <= stk_base | flg_d;
         end else begin
            stk_q <= stk_base;
         end
      end
   end

   // R7: the accepted flags are always folded into the sticky copy
   p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!flg_q.ovf || stk_q.ovf));
   p_sticky_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!flg_q.adv || stk_q.adv));
   // R8: a clear with no operation empties the sticky register
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !load) |=> (stk_q == '0));
endmodule

// File: rtl/msub_sat_unit.sv
module msub_sat_unit #(
   parameter int W           = 64,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         sat_en,
   input  logic [W-1:0] minuend,
   input  logic [W-1:0] subtrahend,
   input  logic         sticky_clr,
   output logic         out_valid,
   output logic [W-1:0] result,
   output logic         ovf,
   output logic         adv,
   output logic         ovf_sticky,
   output logic         adv_sticky
);
   localparam int           MSB       = W - 1;
   localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 4) begin : g_bad_width
         $error("msub_sat_unit: W must be at least 4");
      end
   endgenerate

   logic [W-1:0]          diff_w;
   logic [W-1:0]          res_w;
   msub_pkg::msub_flags_t flg_w;
   msub_pkg::msub_flags_t flg_q;
   msub_pkg::msub_flags_t stk_q;

   msub_diff #(.W(W)) u_diff (
      .a     (minuend),
      .b     (subtrahend),
      .diff  (diff_w),
      .flags (flg_w)
   );

   msub_clamp #(.W(W), .SAT_SUPPORT(SAT_SUPPORT)) u_clamp (
      .sat_en (sat_en),
      .ovf    (flg_w.ovf),
      .a_sign (minuend[MSB]),
      .diff   (diff_w),
      .res    (res_w)
   );

   msub_flag_reg #(.W(W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_valid),
      .clr   (sticky_clr),
      .res_d (res_w),
      .flg_d (flg_w),
      .vld_q (out_valid),
      .res_q (result),
      .flg_q (flg_q),
      .stk_q (stk_q)
   );

   assign ovf        = flg_q.ovf;
   assign adv        = flg_q.adv;
   assign ovf_sticky = stk_q.ovf;
   assign adv_sticky = stk_q.adv;

   // R2: an accepted operation yields a valid output on the next cycle
   p_out_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9: idle cycles leave the registered result and flags alone
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(ovf) && $stable(adv)));
   // R5: a clamped result is one of the two signed limits
   p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (SAT_SUPPORT && in_valid && sat_en && flg_w.ovf)
      |=> (result == POS_LIMIT || result == NEG_LIMIT));
   // R3: without overflow the stored result is the plain difference
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flg_w.ovf) |=> (result == $past(minuend - subtrahend)));
endmodule

// File: tb/tb_msub_sat_unit.sv
module tb_msub_sat_unit;
   localparam int W = 6;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         sat_en = 1'b0;
   logic [W-1:0] minuend = '0;
   logic [W-1:0] subtrahend = '0;
   logic         sticky_clr = 1'b0;
   logic         out_valid;
   logic [W-1:0] result;
   logic         ovf, adv, ovf_sticky, adv_sticky;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   msub_sat_unit #(.W(W), .SAT_SUPPORT(1'b1)) dut (
      .clk, .rst_n, .in_valid, .sat_en, .minuend, .subtrahend, .sticky_clr,
      .out_valid, .result, .ovf, .adv, .ovf_sticky, .adv_sticky
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit st_o, st_a;
      int last_res, last_o, last_a;
      st_o = 0; st_a = 0; last_res = 0; last_o = 0; last_a = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: outputs held at zero during reset
      chk("R1 out_valid", out_valid, 0);
      chk("R1 result", result, 0);
      chk("R1 flags", {ovf, adv, ovf_sticky, adv_sticky}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 result after release", result, 0);
      chk("R1 sticky after release", {ovf_sticky, adv_sticky}, 0);

      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
               int sa, sb, d, wr, er;
               bit eo, ea, clr;
               sa = (a >= M/2) ? a - M : a;
               sb = (b >= M/2) ? b - M : b;
               d  = sa - sb;
               wr = d & (M - 1);
               eo = (d > M/2 - 1) || (d < -(M/2));
               ea = wr[W-1] ^ wr[W-2];
               er = (m == 1 && eo) ? ((sa >= 0) ? (M/2 - 1) : (M/2)) : wr;
               clr = (b == M - 1) && ((a % 8) == 0);
               if (clr) begin st_o = 0; st_a = 0; end
               st_o |= eo; st_a |= ea;
               in_valid = 1'b1; sat_en = m[0];
               minuend = W'(a); subtrahend = W'(b); sticky_clr = clr;
               @(negedge clk);
               chk("R2 out_valid", out_valid, 1);
               if (m == 1 && eo) chk("R5 clamp", result, er);
               else              chk("R3 difference", result, er);
               chk("R4 ovf", ovf, eo);
               chk("R6 adv", adv, ea);
               if (clr) chk("R8 clear with op", {ovf_sticky, adv_sticky}, {st_o, st_a});
               else     chk("R7 sticky", {ovf_sticky, adv_sticky}, {st_o, st_a});
               last_res = er; last_o = eo; last_a = ea;
            end
         end
      end

      // R9: idle cycles with changing operands hold everything
      in_valid = 1'b0; sticky_clr = 1'b0; sat_en = 1'b1;
      minuend = 6'd31; subtrahend = 6'd40;
      @(negedge clk);
      chk("R2 out_valid idle", out_valid, 0);
      @(negedge clk);
      chk("R9 result hold", result, last_res);
      chk("R9 flag hold", {ovf, adv}, {last_o[0], last_a[0]});
      chk("R9 sticky hold", {ovf_sticky, adv_sticky}, {st_o, st_a});

      // make both sticky flags set: 31 - (-9) overflows, raw diff has bits 5/4 = 1/0
      in_valid = 1'b1; sat_en = 1'b0; minuend = 6'd31; subtrahend = 6'd55;
      @(negedge clk);
      chk("R4 ovf directed", ovf, 1);
      chk("R3 wrap directed", result, 40);
      chk("R7 sticky set", {ovf_sticky, adv_sticky}, 3);
      // R8: clear alone leaves result and per-operation flags
      in_valid = 1'b0; sticky_clr = 1'b1;
      @(negedge clk);
      sticky_clr = 1'b0;
      chk("R8 sticky cleared", {ovf_sticky, adv_sticky}, 0);
      chk("R8 result kept", result, 40);
      chk("R8 flags kept", {ovf, adv}, 3);
      // R4: a non-overflowing operation clears ovf
      in_valid = 1'b1; minuend = 6'd5; subtrahend = 6'd3;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R4 ovf cleared", ovf, 0);
      chk("R3 small diff", result, 2);
      @(negedge clk);
      chk("R2 out_valid drop", out_valid, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule